// File: doc/BRIEF.md
# Serial-Bus Synthesizer Control Interface

This block is a two-wire serial target that holds the control settings of a frequency synthesizer and reports one status byte. The clock and data lines are oversampled by the system clock through two-stage synchronisers. Edge and bus-condition detection finds START, repeated START and STOP. A byte-level state machine then recognises the target address, takes in a write burst or sends status bytes during a read. The data line is never driven high. The block only pulls it low, through `sda_oe`.

A write burst has no sub-address byte. The top bit of the first data byte picks the entry point: 0 enters at the first divider byte and 1 enters at the first control byte. The internal pointer then steps through divider-high, divider-low, control-A and control-B. The upper divider bits are held pending and become active together with the lower byte. If the burst ends with STOP after only the high byte, the high bits become active alone. Control fields take effect at the end of their byte. A read returns a status byte that holds a power-on flag and a lock flag. A finished read clears the power-on flag.

Top module: `synth_ctl_i2c`

## Requirements
- R1: The 7-bit target address is binary 11000 followed by `addr_sel[1]`, `addr_sel[0]`, and the eighth address bit is 0 for write and 1 for read. A matching address is acknowledged. A non-matching address is not acknowledged, and the target ignores all traffic until the next START.
- R2: The first data byte of a write burst enters at the divider-high byte when its bit 7 is 0, and at control byte A when its bit 7 is 1. Each later byte of the burst moves to the next register in the order divider-high, divider-low, control A, control B.
- R3: Divider-high bits [6:0] are `div_word[14:8]` and the divider-low byte is `div_word[7:0]`. `div_word` does not change after the divider-high byte alone. All 15 bits change together at the end of the divider-low byte.
- R4: When a STOP ends a burst after the divider-high byte without the divider-low byte, `div_word[14:8]` takes the pending bits and `div_word[7:0]` keeps its value. A repeated START instead discards the pending bits.
- R5: Control byte A bits [6:4] set `mode_bits` and bits [3:1] set `ref_sel`. Control byte B bits [7:6] set `cp_cur`. Each field changes only at the end of its byte.
- R6: Data bytes after control byte B in the same burst are acknowledged and change no output.
- R7: A read acknowledges the address and then sends the status byte MSB first. The byte is bit 7 power-on flag, bit 6 lock flag, and bits 5:0 zero. When the controller acknowledges, another status byte follows. After a not-acknowledge, the target releases the data line.
- R8: The power-on flag is 1 after reset and stays 1 through acknowledged read bytes. It becomes 0 when a read ends with a not-acknowledge.
- R9: The reported lock flag equals `lock_in` while `mode_bits` is 000 or 100, and is 0 in every other mode.
- R10: After reset, `mode_bits` is 001, `div_word`, `ref_sel` and `cp_cur` are zero, and `sda_oe` is 0.
- R11: The bus lines pass through two-flop synchronisers, and `sda_oe` changes only while `scl_in` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low reset, also the supply-low reset |
| addr_sel | input | 2 | Strap value for the two low address bits |
| scl_in | input | 1 | Serial clock line |
| sda_in | input | 1 | Serial data line as seen on the bus |
| lock_in | input | 1 | Synthesizer loop lock indication |
| sda_oe | output | 1 | Pull data line low when 1 |
| div_word | output | 15 | Active main divider ratio |
| mode_bits | output | 3 | Operating/test mode field |
| ref_sel | output | 3 | Reference divider select field |
| cp_cur | output | 2 | Charge pump current select field |

## Verification
The bench builds the block with its default parameters: a 15-bit divider word and two synchroniser stages. This keeps the seven pending divider bits and the full 15-bit commit visible at the ports. The bus half-period is ten system clocks, so the three-cycle delay from synchroniser and edge detection always ends while the clock line is low. Under this timing the rule that the data line moves only while the clock line is low can be checked, and so can every acknowledge slot. A strap value other than zero shows that the address match follows `addr_sel` and is not a fixed value.

// File: rtl/synth_ctl_pkg.sv
package synth_ctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WDATA,
        ST_WACK,
        ST_RDATA,
        ST_RACK,
        ST_IGNORE
    } bus_state_t;

    typedef enum logic [2:0] {
        IDX_DIV_HI = 3'd0,
        IDX_DIV_LO = 3'd1,
        IDX_CTL_A  = 3'd2,
        IDX_CTL_B  = 3'd3,
        IDX_NONE   = 3'd4
    } reg_idx_t;

    localparam logic [4:0] ADDR_PREFIX = 5'b11000;
    localparam logic [2:0] MODE_AT_RESET = 3'b001;

endpackage

// File: rtl/sc_line_sync.sv
module sc_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);
    logic [1:0] raw;
    logic [1:0] synced;
    logic       scl_q, sda_q;

    assign raw = {sda_in, scl_in};

    for (genvar g = 0; g < 2; g++) begin : g_line
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[STAGES-2:0], raw[g]};
        end
        assign synced[g] = chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= synced[0];
            sda_q <= synced[1];
        end
    end

    assign sda_s     = synced[1];
    assign scl_rise  = synced[0] & ~scl_q;
    assign scl_fall  = ~synced[0] & scl_q;
    assign start_evt = synced[0] & scl_q & sda_q & ~synced[1];
    assign stop_evt  = synced[0] & scl_q & ~sda_q & synced[1];

endmodule

// File: rtl/sc_bus_fsm.sv
module sc_bus_fsm
    import synth_ctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sda_s,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       start_evt,
    input  logic       stop_evt,
    input  logic [1:0] addr_sel,
    input  logic [7:0] status_byte,
    output logic       sda_oe,
    output logic [7:0] rx_byte,
    output logic       byte_done,
    output logic       wr_begin,
    output logic       rd_end
);
    bus_state_t state, state_nx;
    logic [7:0] shreg;
    logic [3:0] cnt;
    logic       ack_seen;
    logic       addr_hit;

    assign addr_hit = (shreg[7:3] == ADDR_PREFIX) && (shreg[2:1] == addr_sel);

    // next-state decision
    always_comb begin
        state_nx = state;
        if (stop_evt) begin
            state_nx = ST_IDLE;
        end else if (start_evt) begin
            state_nx = ST_ADDR;
        end else begin
            unique case (state)
                ST_IDLE:     state_nx = ST_IDLE;
                ST_ADDR:     if (scl_fall && cnt == 4'd8)
                                 state_nx = addr_hit ? ST_ADDR_ACK : ST_IGNORE;
                ST_ADDR_ACK: if (scl_fall) state_nx = shreg[0] ? ST_RDATA : ST_WDATA;
                ST_WDATA:    if (scl_fall && cnt == 4'd8) state_nx = ST_WACK;
                ST_WACK:     if (scl_fall) state_nx = ST_WDATA;
                ST_RDATA:    if (scl_fall && cnt == 4'd7) state_nx = ST_RACK;
                ST_RACK:     if (scl_fall) state_nx = ack_seen ? ST_RDATA : ST_IGNORE;
                ST_IGNORE:   state_nx = ST_IGNORE;
            endcase
        end
    end

    // state register and byte datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            shreg    <= '0;
            cnt      <= '0;
            ack_seen <= 1'b0;
        end else begin
            state <= state_nx;
            if (start_evt) begin
                cnt <= '0;
            end else begin
                unique case (state)
                    ST_ADDR, ST_WDATA: if (scl_rise) begin
                        shreg <= {shreg[6:0], sda_s};
                        cnt   <= cnt + 4'd1;
                    end
                    ST_ADDR_ACK: if (scl_fall) begin
                        cnt <= '0;
                        if (shreg[0]) shreg <= status_byte;
                    end
                    ST_WACK: if (scl_fall) cnt <= '0;
                    ST_RDATA: if (scl_fall) begin
                        shreg <= {shreg[6:0], 1'b0};
                        cnt   <= cnt + 4'd1;
                    end
                    ST_RACK: begin
                        if (scl_rise) ack_seen <= ~sda_s;
                        if (scl_fall) begin
                            cnt <= '0;
                            if (ack_seen) shreg <= status_byte;
                        end
                    end
                    ST_IDLE, ST_IGNORE: ;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        sda_oe    = (state == ST_ADDR_ACK) || (state == ST_WACK) ||
                    ((state == ST_RDATA) && !shreg[7]);
        rx_byte   = shreg;
        byte_done = (state == ST_WDATA) && scl_fall && (cnt == 4'd8) && !start_evt && !stop_evt;
        wr_begin  = (state == ST_ADDR_ACK) && scl_fall && !shreg[0] && !start_evt && !stop_evt;
        rd_end    = (state == ST_RACK) && scl_fall && !ack_seen && !start_evt && !stop_evt;
    end

endmodule

// File: rtl/sc_reg_bank.sv
module sc_reg_bank
    import synth_ctl_pkg::*;
#(
    parameter int DIV_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       rx_byte,
    input  logic             byte_done,
    input  logic             wr_begin,
    input  logic             start_evt,
    input  logic             stop_evt,
    output logic [DIV_W-1:0] div_word,
    output logic [2:0]       mode_bits,
    output logic [2:0]       ref_sel,
    output logic [1:0]       cp_cur
);
    localparam int HI_W = DIV_W - 8;

    reg_idx_t        ptr, idx;
    logic            first;
    logic [HI_W-1:0] pend_hi;
    logic            pend_v;

    always_comb begin
        if (first) idx = rx_byte[7] ? IDX_CTL_A : IDX_DIV_HI;
        else       idx = ptr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_word  <= '0;
            mode_bits <= MODE_AT_RESET;
            ref_sel   <= '0;
            cp_cur    <= '0;
            ptr       <= IDX_NONE;
            first     <= 1'b0;
            pend_hi   <= '0;
            pend_v    <= 1'b0;
        end else begin
            if (wr_begin) first <= 1'b1;
            if (byte_done) begin
                first <= 1'b0;
                case (idx)
                    IDX_DIV_HI: begin
                        pend_hi <= rx_byte[HI_W-1:0];
                        pend_v  <= 1'b1;
                    end
                    IDX_DIV_LO: begin
                        div_word <= {pend_hi, rx_byte};
                        pend_v   <= 1'b0;
                    end
                    IDX_CTL_A: begin
                        mode_bits <= rx_byte[6:4];
                        ref_sel   <= rx_byte[3:1];
                    end
                    IDX_CTL_B: cp_cur <= rx_byte[7:6];
                    default: ;
                endcase
                ptr <= (idx == IDX_NONE) ? IDX_NONE : reg_idx_t'(idx + 3'd1);
            end
            if (stop_evt && pend_v) begin
                div_word[DIV_W-1:8] <= pend_hi;
                pend_v <= 1'b0;
            end else if (start_evt) begin
                pend_v <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/synth_ctl_i2c.sv
module synth_ctl_i2c
    import synth_ctl_pkg::*;
#(
    parameter int DIV_W       = 15,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       addr_sel,
    input  logic             scl_in,
    input  logic             sda_in,
    input  logic             lock_in,
    output logic             sda_oe,
    output logic [DIV_W-1:0] div_word,
    output logic [2:0]       mode_bits,
    output logic [2:0]       ref_sel,
    output logic [1:0]       cp_cur
);
    logic       sda_s, scl_rise, scl_fall, start_evt, stop_evt;
    logic [7:0] rx_byte, status_byte;
    logic       byte_done, wr_begin, rd_end;
    logic       por_flag, lock_rep;

    sc_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_evt(start_evt), .stop_evt(stop_evt)
    );

    sc_bus_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_evt(start_evt), .stop_evt(stop_evt),
        .addr_sel(addr_sel), .status_byte(status_byte), .sda_oe(sda_oe),
        .rx_byte(rx_byte), .byte_done(byte_done), .wr_begin(wr_begin),
        .rd_end(rd_end)
    );

    sc_reg_bank #(.DIV_W(DIV_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .rx_byte(rx_byte), .byte_done(byte_done),
        .wr_begin(wr_begin), .start_evt(start_evt), .stop_evt(stop_evt),
        .div_word(div_word), .mode_bits(mode_bits), .ref_sel(ref_sel),
        .cp_cur(cp_cur)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      por_flag <= 1'b1;
        else if (rd_end) por_flag <= 1'b0;
    end

    assign lock_rep    = lock_in && (mode_bits == 3'b000 || mode_bits == 3'b100);
    assign status_byte = {por_flag, lock_rep, 6'b000000};

endmodule

// File: rtl/sc_checker.sv
module sc_checker #(
    parameter int DIV_W = 15
) (
    input logic             clk,
    input logic             rst_n,
    input logic             scl_in,
    input logic             sda_oe,
    input logic [DIV_W-1:0] div_word,
    input logic [2:0]       mode_bits,
    input logic [2:0]       ref_sel,
    input logic [1:0]       cp_cur,
    input logic             byte_done,
    input logic             stop_evt,
    input logic             rd_end,
    input logic             por_flag
);
    assert_oe_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !scl_in);

    assert_reset_state_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (mode_bits == 3'b001 && div_word == '0 && !sda_oe));

    assert_div_commit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (div_word != $past(div_word)) |-> ($past(byte_done) || $past(stop_evt)));

    assert_ctl_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ({mode_bits, ref_sel, cp_cur} != $past({mode_bits, ref_sel, cp_cur})) |-> $past(byte_done));

    assert_por_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!por_flag && $past(por_flag)) |-> $past(rd_end));

endmodule

bind synth_ctl_i2c sc_checker #(.DIV_W(DIV_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_oe(sda_oe),
    .div_word(div_word), .mode_bits(mode_bits), .ref_sel(ref_sel),
    .cp_cur(cp_cur), .byte_done(byte_done), .stop_evt(stop_evt),
    .rd_end(rd_end), .por_flag(por_flag)
);

// File: tb/synth_ctl_i2c_bench.sv
module synth_ctl_i2c_bench;
    localparam int H = 10;

    typedef struct packed {
        logic [3:0]  n;
        logic [31:0] bytes;
        logic [15:0] exp_div;
        logic [7:0]  exp_ctl;
    } vec_t;

    localparam vec_t VEC [6] = '{
        '{4'd4, 32'h1234C680, 16'h1234, 8'h8E},
        '{4'd2, 32'hAA400000, 16'h1234, 8'h55},
        '{4'd1, 32'h7F000000, 16'h7F34, 8'h55},
        '{4'd2, 32'h01000000, 16'h0100, 8'h55},
        '{4'd3, 32'h05FFF000, 16'h05FF, 8'hE1},
        '{4'd1, 32'h90000000, 16'h05FF, 8'h21}
    };

    logic        clk = 0;
    logic        rst_n = 0;
    logic [1:0]  addr_sel = 2'b00;
    logic        scl_m = 1, sda_m = 1, lock_in = 0;
    logic        sda_line;
    logic        sda_oe;
    logic [14:0] div_word;
    logic [2:0]  mode_bits, ref_sel;
    logic [1:0]  cp_cur;
    int          n_cmp = 0, n_bad = 0;
    logic        ackv;
    logic [7:0]  rb;

    assign sda_line = sda_m & ~sda_oe;
    always #10 clk = ~clk;

    synth_ctl_i2c u_synth_ctl_i2c (
        .clk(clk), .rst_n(rst_n), .addr_sel(addr_sel), .scl_in(scl_m),
        .sda_in(sda_line), .lock_in(lock_in), .sda_oe(sda_oe),
        .div_word(div_word), .mode_bits(mode_bits), .ref_sel(ref_sel),
        .cp_cur(cp_cur)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic w(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start;
        sda_m = 1; w(H); scl_m = 1; w(H); sda_m = 0; w(H); scl_m = 0; w(H);
    endtask

    task automatic bus_stop;
        sda_m = 0; w(H); scl_m = 1; w(H); sda_m = 1; w(H);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; w(H); scl_m = 1; w(H); scl_m = 0;
        end
        sda_m = 1; w(H); scl_m = 1; w(H/2); ack = !sda_line; w(H/2); scl_m = 0; w(H);
    endtask

    task automatic recv_byte(input logic ack_m, output logic [7:0] b);
        sda_m = 1;
        for (int i = 7; i >= 0; i--) begin
            w(H); scl_m = 1; w(H/2); b[i] = sda_line; w(H/2); scl_m = 0;
        end
        sda_m = !ack_m; w(H); scl_m = 1; w(H); scl_m = 0; sda_m = 1; w(H);
    endtask

    task automatic do_reset;
        rst_n = 0; scl_m = 1; sda_m = 1; w(5); rst_n = 1; w(5);
    endtask

    function automatic logic [7:0] ctl_now();
        return {mode_bits, ref_sel, cp_cur};
    endfunction

    bit finished = 0;
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++; n_cmp++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R10 reset state
        chk("R10 sda_oe", {31'd0, sda_oe}, 0);
        chk("R10 mode", {29'd0, mode_bits}, 32'h1);
        chk("R10 div", {17'd0, div_word}, 0);
        chk("R10 ref/cp", {27'd0, ref_sel, cp_cur}, 0);

        // table of write bursts: R2 R3 R4 R5, acks R1
        foreach (VEC[k]) begin
            bus_start();
            send_byte(8'hC0, ackv);
            chk("R1 address ack", {31'd0, ackv}, 1);
            for (int j = 0; j < VEC[k].n; j++) begin
                send_byte(VEC[k].bytes[31-8*j -: 8], ackv);
                chk("R2 data ack", {31'd0, ackv}, 1);
            end
            bus_stop(); w(4);
            chk("R3/R4 div after burst", {17'd0, div_word}, {16'd0, VEC[k].exp_div});
            chk("R2/R5 control after burst", {24'd0, ctl_now()}, {24'd0, VEC[k].exp_ctl});
        end

        // R3 divider held until low byte
        bus_start(); send_byte(8'hC0, ackv);
        send_byte(8'h2A, ackv); w(4);
        chk("R3 div held after high byte", {17'd0, div_word}, 32'h05FF);
        send_byte(8'h11, ackv); w(4);
        chk("R3 div after low byte", {17'd0, div_word}, 32'h2A11);
        bus_stop();

        // R4 repeated START discards pending high bits
        bus_start(); send_byte(8'hC0, ackv); send_byte(8'h33, ackv);
        bus_start(); send_byte(8'hC0, ackv); send_byte(8'h90, ackv);
        bus_stop(); w(4);
        chk("R4 repeated start abort", {17'd0, div_word}, 32'h2A11);
        chk("R4 second burst control", {24'd0, ctl_now()}, 32'h21);

        // R6 extra bytes
        bus_start(); send_byte(8'hC0, ackv);
        send_byte(8'h00, ackv); send_byte(8'h01, ackv);
        send_byte(8'h80, ackv); send_byte(8'hC0, ackv);
        send_byte(8'hAA, ackv);
        chk("R6 extra byte ack", {31'd0, ackv}, 1);
        bus_stop(); w(4);
        chk("R6 div", {17'd0, div_word}, 32'h0001);
        chk("R6 control", {24'd0, ctl_now()}, 32'h03);

        // R1 wrong address ignored
        bus_start(); send_byte(8'hC4, ackv);
        chk("R1 mismatch no ack", {31'd0, ackv}, 0);
        send_byte(8'h8C, ackv);
        chk("R1 ignored data no ack", {31'd0, ackv}, 0);
        bus_stop(); w(4);
        chk("R1 ignored no change", {24'd0, ctl_now()}, 32'h03);

        // R1 strap-selected address
        addr_sel = 2'b10;
        bus_start(); send_byte(8'hC4, ackv);
        chk("R1 strap address ack", {31'd0, ackv}, 1);
        send_byte(8'h8C, ackv); bus_stop(); w(4);
        chk("R1 strap write", {24'd0, ctl_now()}, 32'h1B);
        addr_sel = 2'b00;

        // R7 R8 R9 reads, mode 000 normal
        lock_in = 1;
        bus_start(); send_byte(8'hC1, ackv);
        chk("R7 read address ack", {31'd0, ackv}, 1);
        recv_byte(1'b1, rb);
        chk("R7 status byte 1", {24'd0, rb}, 32'hC0);
        recv_byte(1'b0, rb);
        chk("R8 por kept across ack", {24'd0, rb}, 32'hC0);
        chk("R7 released after nack", {31'd0, sda_oe}, 0);
        bus_stop();
        bus_start(); send_byte(8'hC1, ackv); recv_byte(1'b0, rb); bus_stop();
        chk("R8 por cleared", {24'd0, rb}, 32'h40);

        // R9 lock masked outside normal modes
        bus_start(); send_byte(8'hC0, ackv); send_byte(8'h90, ackv); bus_stop();
        bus_start(); send_byte(8'hC1, ackv); recv_byte(1'b0, rb); bus_stop();
        chk("R9 lock masked mode 001", {24'd0, rb}, 32'h00);
        bus_start(); send_byte(8'hC0, ackv); send_byte(8'hC0, ackv); bus_stop();
        bus_start(); send_byte(8'hC1, ackv); recv_byte(1'b0, rb); bus_stop();
        chk("R9 lock shown mode 100", {24'd0, rb}, 32'h40);

        // R8 R10 reset again sets por
        do_reset();
        chk("R10 mode after second reset", {29'd0, mode_bits}, 32'h1);
        bus_start(); send_byte(8'hC1, ackv); recv_byte(1'b0, rb); bus_stop();
        chk("R8 por after reset", {24'd0, rb}, 32'h80);

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule